// File: doc/BRIEF.md
# USB Wrapper Interrupt Aggregator

This block sits next to a USB on-the-go controller core and turns the core's many single-cycle event pulses into one level-sensitive interrupt line. Endpoint events (one transmit and one receive pulse per endpoint) are gathered into a 32-bit endpoint word. Nine core events are gathered into a 9-bit core word, and the top bit of that word marks a change of the VBUS drive request. Each word keeps its own pending bits and its own enable mask. Software enables or disables sources by writing ones to separate set and clear addresses, and acknowledges events by writing ones to the pending address.

The interrupt line follows an arm/fire/acknowledge cycle. When the line is armed and any enabled source is pending, the line rises and disarms itself. It then stays high until software writes the end-of-interrupt address. Writing one there lowers the line and re-arms it. Writing zero lowers the line but leaves it disarmed. Around this core function the block also holds a nonzero revision word, a self-clearing soft-reset request for the attached core, a live view of the VBUS drive level, an OTG-disable control bit and a live view of the ID pin.

Access is through a plain 32-bit register port. Every access completes in the cycle it is presented, so there is no back-pressure. Reads are combinational and have no side effects. A write takes effect at the clock edge where `reg_wr` is high. All event inputs are single-cycle pulses that are sampled at each edge.

Top module: `usb_irq_wrap`

## Requirements
- R1: The revision word at byte offset 0x00 reads the nonzero value of parameter REV_ID. Writes to it have no effect.
- R2: Endpoint word layout: transmit event of endpoint n sets bit n (n = 0..15). Receive event of endpoint n sets bit 16+n (n = 1..15). Bit 16 never becomes set in the pending bits or in the enable mask, and the receive input of endpoint 0 is ignored.
- R3: Core word layout: core event k sets bit k (k = 0..8), and bit 8 is the VBUS-drive-change event. Bits 31:9 of the core pending (0x34) and core enable (0x3C/0x44) addresses read 0.
- R4: Pending bits (endpoint 0x30, core 0x34) latch events whether or not the source is enabled. Writing ones clears those bits. An event that arrives in the same cycle as the clearing write stays pending.
- R5: Writing ones to an enable-set address (endpoint 0x38, core 0x3C) enables those sources. Writing ones to an enable-clear address (endpoint 0x40, core 0x44) disables them. Reading either address returns the current mask.
- R6: When the line is armed and any source is both pending and enabled, `irq` goes high at the next clock edge. A pending source that is not enabled never raises it.
- R7: Once high, `irq` stays high and the line stays disarmed until a write to 0x24. Data bit 0 = 1 lowers the line and re-arms it, so it rises again one edge later if an enabled source is still pending. Data bit 0 = 0 lowers the line and leaves it disarmed.
- R8: Writing a 1 in bit 0 of the control address 0x14 produces a one-cycle high pulse on `core_rst` after that edge. The control address reads 0.
- R9: Bit 0 of the status address 0x18 returns the live level of `vbus_drv`. The other bits read 0.
- R10: Bit 21 of the PHY control address 0xE0 is read/write, drives `otg_dis` and resets to 1. Its other bits read 0. Bit 8 of the mode address 0xE8 returns the live `id_pin` level, and writes to 0xE8 are ignored.
- R11: Addresses not listed above read 0, and writes to them change nothing.
- R12: After reset, all pending bits and enable masks are 0, `irq` and `core_rst` are low, and the line is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Byte address; bits 1:0 ignored |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ep_tx_evt | input | NUM_EP | Per-endpoint transmit event pulses |
| ep_rx_evt | input | NUM_EP | Per-endpoint receive event pulses; bit 0 ignored |
| core_evt | input | 9 | Core event pulses; bit 8 is the VBUS-drive change |
| vbus_drv | input | 1 | Live VBUS drive request level |
| id_pin | input | 1 | Live ID pin level |
| irq | output | 1 | Level interrupt line |
| core_rst | output | 1 | Soft-reset pulse to the attached core |
| otg_dis | output | 1 | OTG-disable control to the PHY |

## Verification
The bench probes the race between an event and a clearing write in the same cycle. A design that applies the clear after the event would silently lose that event. It checks that the line stays high after the pending bits are cleared, and stays low after an end-of-interrupt write of zero even while a new enabled event is pending. A design that treats the line as a plain OR of pending and enabled bits would drop early or fire again. It also checks the hole at endpoint bit 16 and the ignored receive input of endpoint 0, which a design with a naive shift-and-OR layout would expose. Finally it checks that re-arming with a source still pending raises the line one edge later and not in the same cycle.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;

  // register byte offsets
  localparam logic [ADDR_W-1:0] OFF_REV        = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_CTRL       = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_STAT       = 12'h018;
  localparam logic [ADDR_W-1:0] OFF_EOI        = 12'h024;
  localparam logic [ADDR_W-1:0] OFF_EP_PEND    = 12'h030;
  localparam logic [ADDR_W-1:0] OFF_CORE_PEND  = 12'h034;
  localparam logic [ADDR_W-1:0] OFF_EP_ENSET   = 12'h038;
  localparam logic [ADDR_W-1:0] OFF_CORE_ENSET = 12'h03C;
  localparam logic [ADDR_W-1:0] OFF_EP_ENCLR   = 12'h040;
  localparam logic [ADDR_W-1:0] OFF_CORE_ENCLR = 12'h044;
  localparam logic [ADDR_W-1:0] OFF_PHY        = 12'h0E0;
  localparam logic [ADDR_W-1:0] OFF_MODE       = 12'h0E8;

  // field positions
  localparam int CORE_EVT_N  = 9;
  localparam int RX_BASE     = 16;
  localparam int MAX_EP      = 16;
  localparam int SRST_BIT    = 0;
  localparam int OTGDIS_BIT  = 21;
  localparam int ID_BIT      = 8;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_REV,
    SEL_CTRL,
    SEL_STAT,
    SEL_EOI,
    SEL_EP_PEND,
    SEL_CORE_PEND,
    SEL_EP_ENSET,
    SEL_CORE_ENSET,
    SEL_EP_ENCLR,
    SEL_CORE_ENCLR,
    SEL_PHY,
    SEL_MODE
  } reg_sel_e;

  typedef struct packed {
    logic pend_w1c;
    logic en_set;
    logic en_clr;
  } bank_wr_t;

  // bits of the endpoint word that an endpoint can drive
  function automatic logic [DATA_W-1:0] ep_valid_mask(input int n_ep);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_EP; i++) begin
      if (i < n_ep) begin
        m[i] = 1'b1;
        if (i > 0) m[RX_BASE+i] = 1'b1;
      end
    end
    return m;
  endfunction

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] w;
    w = a & ~ADDR_W'(3);
    case (w)
      OFF_REV:        return SEL_REV;
      OFF_CTRL:       return SEL_CTRL;
      OFF_STAT:       return SEL_STAT;
      OFF_EOI:        return SEL_EOI;
      OFF_EP_PEND:    return SEL_EP_PEND;
      OFF_CORE_PEND:  return SEL_CORE_PEND;
      OFF_EP_ENSET:   return SEL_EP_ENSET;
      OFF_CORE_ENSET: return SEL_CORE_ENSET;
      OFF_EP_ENCLR:   return SEL_EP_ENCLR;
      OFF_CORE_ENCLR: return SEL_CORE_ENCLR;
      OFF_PHY:        return SEL_PHY;
      OFF_MODE:       return SEL_MODE;
      default:        return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/usbirq_bank.sv
module usbirq_bank
  import usbirq_pkg::*;
#(
  parameter int           W     = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  bank_wr_t     wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] en_o,
  output logic         active_o
);

  logic [W-1:0] pend_q, pend_d;
  logic [W-1:0] en_q, en_d;
  logic [W-1:0] clr_mask;

  // clear first, then merge new events so a racing event survives
  always_comb begin
    clr_mask = wr_i.pend_w1c ? wdata_i : '0;
    pend_d   = ((pend_q & ~clr_mask) | evt_i) & VALID;
  end

  always_comb begin
    en_d = en_q;
    if (wr_i.en_set)      en_d = (en_q | wdata_i) & VALID;
    else if (wr_i.en_clr) en_d = en_q & ~wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
    end
  end

  assign pend_o   = pend_q;
  assign en_o     = en_q;
  assign active_o = |(pend_q & en_q);

  AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    |(evt_i & VALID) |=> ((pend_q & $past(evt_i & VALID)) == $past(evt_i & VALID))); // R4
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i.pend_w1c |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i.pend_w1c |=> ((pend_q & $past(wdata_i & ~evt_i)) == '0)); // R4
  AST_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i.en_set || wr_i.en_clr) |=> $stable(en_q)); // R5

endmodule

// File: rtl/usbirq_line.sv
module usbirq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic eoi_we_i,
  input  logic eoi_arm_i,
  output logic irq_o
);

  logic irq_q;
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      armed_q <= 1'b1;
    end else if (eoi_we_i) begin
      irq_q   <= 1'b0;
      armed_q <= armed_q | eoi_arm_i;
    end else if (armed_q && active_i) begin
      irq_q   <= 1'b1;
      armed_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !eoi_we_i) |=> irq_q); // R7
  AST_EOI_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_we_i |=> !irq_q); // R7
  AST_RISE_WHEN_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(armed_q)); // R6
  AST_RISE_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(active_i)); // R6

endmodule

// File: rtl/usbirq_misc.sv
module usbirq_misc (
  input  logic clk,
  input  logic rst_n,
  input  logic srst_we_i,
  input  logic srst_bit_i,
  input  logic phy_we_i,
  input  logic otgdis_bit_i,
  output logic core_rst_o,
  output logic otg_dis_o
);

  logic rst_pulse_q;
  logic otg_dis_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pulse_q <= 1'b0;
      otg_dis_q   <= 1'b1;
    end else begin
      rst_pulse_q <= srst_we_i & srst_bit_i;
      if (phy_we_i) otg_dis_q <= otgdis_bit_i;
    end
  end

  assign core_rst_o = rst_pulse_q;
  assign otg_dis_o  = otg_dis_q;

  AST_SRST_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_o |-> $past(srst_we_i && srst_bit_i)); // R8
  AST_PHY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_we_i |=> $stable(otg_dis_q)); // R10

endmodule

// File: rtl/usb_irq_wrap.sv
module usb_irq_wrap
  import usbirq_pkg::*;
#(
  parameter int          NUM_EP = 16,
  parameter logic [31:0] REV_ID = 32'h5A17_0103
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_EP-1:0] ep_tx_evt,
  input  logic [NUM_EP-1:0] ep_rx_evt,
  input  logic [8:0]        core_evt,
  input  logic              vbus_drv,
  input  logic              id_pin,
  output logic              irq,
  output logic              core_rst,
  output logic              otg_dis
);

  localparam logic [DATA_W-1:0]     EP_VALID   = ep_valid_mask(NUM_EP);
  localparam logic [CORE_EVT_N-1:0] CORE_VALID = '1;

  reg_sel_e               sel;
  logic [DATA_W-1:0]      ep_evt;
  logic [DATA_W-1:0]      ep_pend, ep_en;
  logic [CORE_EVT_N-1:0]  core_pend, core_en;
  logic                   ep_active, core_active;
  bank_wr_t               ep_wr, core_wr;
  logic                   eoi_we, srst_we, phy_we;
  logic                   unused_rx0;

  assign sel = decode_addr(reg_addr);

  // endpoint word: TX low half, RX upper half with bit 16 left empty
  for (genvar b = 0; b < DATA_W; b++) begin : g_epmap
    if (b < NUM_EP) begin : g_tx
      assign ep_evt[b] = ep_tx_evt[b];
    end else if ((b > RX_BASE) && ((b - RX_BASE) < NUM_EP)) begin : g_rx
      assign ep_evt[b] = ep_rx_evt[b-RX_BASE];
    end else begin : g_none
      assign ep_evt[b] = 1'b0;
    end
  end

  assign unused_rx0 = ep_rx_evt[0];

  always_comb begin
    ep_wr.pend_w1c   = reg_wr && (sel == SEL_EP_PEND);
    ep_wr.en_set     = reg_wr && (sel == SEL_EP_ENSET);
    ep_wr.en_clr     = reg_wr && (sel == SEL_EP_ENCLR);
    core_wr.pend_w1c = reg_wr && (sel == SEL_CORE_PEND);
    core_wr.en_set   = reg_wr && (sel == SEL_CORE_ENSET);
    core_wr.en_clr   = reg_wr && (sel == SEL_CORE_ENCLR);
    eoi_we           = reg_wr && (sel == SEL_EOI);
    srst_we          = reg_wr && (sel == SEL_CTRL);
    phy_we           = reg_wr && (sel == SEL_PHY);
  end

  usbirq_bank #(.W(DATA_W), .VALID(EP_VALID)) i_ep_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (ep_evt),
    .wr_i     (ep_wr),
    .wdata_i  (reg_wdata),
    .pend_o   (ep_pend),
    .en_o     (ep_en),
    .active_o (ep_active)
  );

  usbirq_bank #(.W(CORE_EVT_N), .VALID(CORE_VALID)) i_core_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (core_evt),
    .wr_i     (core_wr),
    .wdata_i  (reg_wdata[CORE_EVT_N-1:0]),
    .pend_o   (core_pend),
    .en_o     (core_en),
    .active_o (core_active)
  );

  usbirq_line i_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .active_i  (ep_active | core_active),
    .eoi_we_i  (eoi_we),
    .eoi_arm_i (reg_wdata[0]),
    .irq_o     (irq)
  );

  usbirq_misc i_misc (
    .clk          (clk),
    .rst_n        (rst_n),
    .srst_we_i    (srst_we),
    .srst_bit_i   (reg_wdata[SRST_BIT]),
    .phy_we_i     (phy_we),
    .otgdis_bit_i (reg_wdata[OTGDIS_BIT]),
    .core_rst_o   (core_rst),
    .otg_dis_o    (otg_dis)
  );

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_REV:        reg_rdata = REV_ID;
      SEL_STAT:       reg_rdata[0] = vbus_drv;
      SEL_EP_PEND:    reg_rdata = ep_pend;
      SEL_CORE_PEND:  reg_rdata[CORE_EVT_N-1:0] = core_pend;
      SEL_EP_ENSET,
      SEL_EP_ENCLR:   reg_rdata = ep_en;
      SEL_CORE_ENSET,
      SEL_CORE_ENCLR: reg_rdata[CORE_EVT_N-1:0] = core_en;
      SEL_PHY:        reg_rdata[OTGDIS_BIT] = otg_dis;
      SEL_MODE:       reg_rdata[ID_BIT] = id_pin;
      default:        reg_rdata = '0;
    endcase
  end

  AST_IRQ_LOW_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (|$past(ep_pend & ep_en) || |$past(core_pend & core_en))); // R6
  AST_SRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !srst_we |=> !core_rst); // R8

endmodule

// File: tb/test_usb_irq_wrap.sv
`timescale 1ns/1ps
module test_usb_irq_wrap;

  localparam logic [31:0] TB_REV = 32'h5A17_0103;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] ep_tx_evt = '0;
  logic [15:0] ep_rx_evt = '0;
  logic [8:0]  core_evt = '0;
  logic        vbus_drv = 1'b0;
  logic        id_pin = 1'b1;
  logic        irq, core_rst, otg_dis;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  usb_irq_wrap #(.NUM_EP(16), .REV_ID(TB_REV)) i_usb_irq_wrap (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ep_tx_evt(ep_tx_evt),
    .ep_rx_evt(ep_rx_evt), .core_evt(core_evt), .vbus_drv(vbus_drv),
    .id_pin(id_pin), .irq(irq), .core_rst(core_rst), .otg_dis(otg_dis)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 12'h000, 32'h0000_0000, TB_REV,        8'd1},  // R1 read
    '{1'b1, 12'h000, 32'h0000_0000, TB_REV,        8'd1},  // R1 write ignored
    '{1'b1, 12'h0E0, 32'hFFFF_FFFF, 32'h0020_0000, 8'd10}, // R10 only bit 21
    '{1'b1, 12'h0E0, 32'h0000_0000, 32'h0000_0000, 8'd10}, // R10
    '{1'b1, 12'h038, 32'hFFFF_FFFF, 32'hFFFE_FFFF, 8'd2},  // R2 bit 16 hole
    '{1'b0, 12'h040, 32'h0000_0000, 32'hFFFE_FFFF, 8'd5},  // R5 clr reads mask
    '{1'b1, 12'h040, 32'h0000_FFFF, 32'hFFFE_0000, 8'd5},  // R5
    '{1'b1, 12'h03C, 32'hFFFF_FFFF, 32'h0000_01FF, 8'd3},  // R3
    '{1'b1, 12'h044, 32'h0000_00FF, 32'h0000_0100, 8'd5},  // R5
    '{1'b1, 12'h080, 32'h1234_5678, 32'h0000_0000, 8'd11}, // R11
    '{1'b1, 12'h014, 32'h0000_0000, 32'h0000_0000, 8'd8},  // R8 reads 0
    '{1'b1, 12'h0E8, 32'h0000_0000, 32'h0000_0100, 8'd10}, // R10 id live
    '{1'b0, 12'h018, 32'h0000_0000, 32'h0000_0000, 8'd9}   // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [15:0] tx, input logic [15:0] rx, input logic [8:0] ce);
    @(negedge clk);
    ep_tx_evt = tx; ep_rx_evt = rx; core_evt = ce;
    @(negedge clk);
    ep_tx_evt = '0; ep_rx_evt = '0; core_evt = '0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got hung expected finish");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 irq", {31'b0, irq}, 32'd0);
    chk("R12 core_rst", {31'b0, core_rst}, 32'd0);
    chk("R10 otg_dis reset", {31'b0, otg_dis}, 32'd1);
    rd(12'h030, v); chk("R12 ep pend", v, 32'd0);
    rd(12'h03C, v); chk("R12 core en", v, 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (TBL[i].wr) wr(TBL[i].addr, TBL[i].wd);
      rd(TBL[i].addr, v);
      chk($sformatf("R%0d table row %0d", TBL[i].req, i), v, TBL[i].exp);
    end
    chk("R10 otg_dis pin", {31'b0, otg_dis}, 32'd0);

    // R8 soft reset pulse
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 12'h014; reg_wdata = 32'd1;
    @(posedge clk); #1;
    chk("R8 pulse high", {31'b0, core_rst}, 32'd1);
    @(negedge clk);
    reg_wr = 1'b0;
    @(posedge clk); #1;
    chk("R8 pulse low", {31'b0, core_rst}, 32'd0);

    // R9 live drive level
    @(negedge clk);
    vbus_drv = 1'b1;
    rd(12'h018, v); chk("R9 vbus high", v, 32'd1);
    vbus_drv = 1'b0;

    // R4 disabled event latches, R6 no irq
    pulse(16'h0008, 16'h0000, 9'h000);
    rd(12'h030, v); chk("R4 latch disabled", v, 32'h0000_0008);
    @(negedge clk); @(negedge clk);
    chk("R6 disabled no irq", {31'b0, irq}, 32'd0);

    // R2 endpoint 0 rx ignored
    pulse(16'h0000, 16'h0001, 9'h000);
    rd(12'h030, v); chk("R2 rx0 ignored", v, 32'h0000_0008);

    // R2 rx5 -> bit 21, R6 irq one edge later
    pulse(16'h0000, 16'h0020, 9'h000);
    rd(12'h030, v); chk("R2 rx5 bit21", v, 32'h0020_0008);
    chk("R6 irq not yet", {31'b0, irq}, 32'd0);
    @(negedge clk);
    chk("R6 irq rises", {31'b0, irq}, 32'd1);

    // R4 clear, R7 line held
    wr(12'h030, 32'h0020_0008);
    rd(12'h030, v); chk("R4 w1c", v, 32'd0);
    repeat (3) @(negedge clk);
    chk("R7 held after clear", {31'b0, irq}, 32'd1);

    // R7 eoi 0 drops, stays disarmed
    wr(12'h024, 32'd0);
    chk("R7 eoi0 drops", {31'b0, irq}, 32'd0);
    pulse(16'h0000, 16'h0020, 9'h000);
    repeat (3) @(negedge clk);
    chk("R7 disarmed", {31'b0, irq}, 32'd0);

    // R7 eoi 1 re-arms
    wr(12'h024, 32'd1);
    chk("R7 eoi1 low", {31'b0, irq}, 32'd0);
    @(negedge clk);
    chk("R7 refire", {31'b0, irq}, 32'd1);

    // R4 event racing a clearing write stays pending
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 12'h030; reg_wdata = 32'h0020_0000; ep_rx_evt = 16'h0020;
    @(negedge clk);
    reg_wr = 1'b0; ep_rx_evt = '0;
    rd(12'h030, v); chk("R4 race kept", v, 32'h0020_0000);

    // R3 core word, R7 re-arm through core source
    wr(12'h030, 32'hFFFF_FFFF);
    wr(12'h024, 32'd0);
    pulse(16'h0000, 16'h0000, 9'h1FF);
    rd(12'h034, v); chk("R3 core pend", v, 32'h0000_01FF);
    chk("R7 still disarmed", {31'b0, irq}, 32'd0);
    wr(12'h024, 32'd1);
    @(negedge clk);
    chk("R3 vbus change irq", {31'b0, irq}, 32'd1);

    summary();
  end

endmodule